// File: doc/BRIEF.md
# Tiered Overcurrent Protection Controller

This controller sits behind a set of ideal comparator flags in a battery pack and decides when to open the discharge switch. It watches three rising overcurrent flags, a supply-low flag and a load-release flag. Each fault condition must persist for its own number of ticks of a slow timing strobe before it counts. A qualified overcurrent fault latches until the load side reports release. A qualified undervoltage lockout clears as soon as the supply recovers. While any fault is held, the controller drives the gate-control output to its fault level and enables a pulldown on the load-sense pin.

The tier-2 fault uses a repeating window. The window starts when the tier-1 flag rises, not when the tier-2 flag rises. A tier-2 flag that comes late is therefore caught at the next window boundary, which is at most one window after it appears. The delay counts, the presence of the tier-3 path and the output polarity are all fixed at build time. The gate output is given as a drive-enable bit and a pin-level bit, so that a released (high-impedance) gate can be told apart from a driven one.

Top module: `ocp_ctrl`

## Requirements
- R1: After reset the controller is in the normal state, the gate is at its normal level and `sense_pd_o` is 0.
- R2: The tier-1 fault trips on the T1_TICKS-th tick during which `oc1_flag_i` has been held high without a break. Dropping `oc1_flag_i` earlier prevents the trip and restarts the count.
- R3: Delay counters advance only in cycles where `tick_i` is 1. A flag held for any number of cycles without a tick never trips.
- R4: While `oc1_flag_i` is high, a window of T2_TICKS ticks repeats, measured from the rise of `oc1_flag_i`. At a window end the tier-2 fault trips if `oc2_flag_i` was high in any cycle of that window. Dropping `oc1_flag_i` restarts the window.
- R5: With TIER3_EN=1, the tier-3 fault trips on the T3_TICKS-th tick of `oc3_flag_i` held high. With TIER3_EN=0, `oc3_flag_i` has no effect on the outputs.
- R6: An overcurrent fault holds while `release_i` is 0, even if every overcurrent flag drops. It returns to normal on the clock edge at which `release_i` is 1.
- R7: Undervoltage lockout trips on the UV_TICKS-th tick of `uv_flag_i` held high. It returns to normal on the first clock edge at which `uv_flag_i` is 0, whatever `release_i` is.
- R8: When a lockout and an overcurrent fault qualify on the same tick, the controller enters lockout.
- R9: `sense_pd_o` is 1 exactly while the controller is in either fault state.
- R10: The value `gate_lvl_o` is the pin level, assuming an external pull-up: 0 while driven and 1 while released. With ACT_HIGH=0 the gate is released when normal and driven on a fault (`gate_oe_o`=1, `gate_lvl_o`=0). With ACT_HIGH=1 the gate is driven low when normal and released on a fault (`gate_oe_o`=0, `gate_lvl_o`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow timing strobe, one clock wide |
| oc1_flag_i | input | 1 | Sense voltage at or above tier-1 threshold |
| oc2_flag_i | input | 1 | Sense voltage at or above tier-2 threshold |
| oc3_flag_i | input | 1 | Sense voltage at or above tier-3 threshold |
| uv_flag_i | input | 1 | Supply at or below lockout threshold |
| release_i | input | 1 | Load-side difference has reached release level |
| gate_oe_o | output | 1 | Gate pin driven (1) or released (0) |
| gate_lvl_o | output | 1 | Resolved gate pin level |
| sense_pd_o | output | 1 | Load-sense pulldown enable |

## Verification
A lockout and an overcurrent fault can qualify on the same tick. In that case the lockout must win. To provoke this, the supply-low flag is raised two ticks ahead of the tier-1 and tier-3 flags, so the lockout count (four ticks) and the tier-3 count (two ticks) end on the same tick. The outcome is judged at the ports. All flags are dropped while `release_i` stays low. A controller in lockout returns to normal on the next edge, but one that had latched an overcurrent fault would stay faulted.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_OC   = 2'd1,
    ST_UVLO = 2'd2
  } ocp_state_e;

  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ocp_delay.sv
// Persistence qualifier: hit after CNT ticks of continuous arm.
module ocp_delay #(
  parameter int unsigned CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned W = ocp_pkg::cnt_bits(CNT);
  localparam logic [W-1:0] LAST = W'(CNT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = arm_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!arm_i || hit_o)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ocp_window.sv
// Repeating window armed by tier 1; trips at a boundary if seen_i occurred.
module ocp_window #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  input  logic seen_i,
  output logic hit_o
);
  localparam int unsigned W = ocp_pkg::cnt_bits(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;
  logic         seen_q;
  logic         at_end;

  assign at_end = arm_i & tick_i & (cnt_q == LAST);
  assign hit_o  = at_end & (seen_q | seen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!arm_i || at_end) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q  <= cnt_q + 1'b1;
      if (seen_i) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl #(
  parameter int unsigned T1_TICKS = 4025,
  parameter int unsigned T2_TICKS = 4,
  parameter int unsigned T3_TICKS = 1,
  parameter int unsigned UV_TICKS = 17,
  parameter bit          TIER3_EN = 1'b1,
  parameter bit          ACT_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic oc1_flag_i,
  input  logic oc2_flag_i,
  input  logic oc3_flag_i,
  input  logic uv_flag_i,
  input  logic release_i,
  output logic gate_oe_o,
  output logic gate_lvl_o,
  output logic sense_pd_o
);
  import ocp_pkg::*;

  ocp_state_e state_q, state_d;
  logic       in_norm;
  logic       hit1, hit2, hit3, hit_uv;
  logic       oc_hit;
  logic       fault;

  assign in_norm = (state_q == ST_NORM);

  ocp_delay #(.CNT(T1_TICKS)) u_tier1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(in_norm & oc1_flag_i),
    .tick_i(tick_i), .hit_o(hit1)
  );

  ocp_window #(.LEN(T2_TICKS)) u_tier2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(in_norm & oc1_flag_i),
    .tick_i(tick_i), .seen_i(oc2_flag_i), .hit_o(hit2)
  );

  generate
    if (TIER3_EN) begin : g_tier3
      ocp_delay #(.CNT(T3_TICKS)) u_tier3 (
        .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(in_norm & oc3_flag_i),
        .tick_i(tick_i), .hit_o(hit3)
      );
    end else begin : g_no_tier3
      assign hit3 = 1'b0;
    end
  endgenerate

  ocp_delay #(.CNT(UV_TICKS)) u_uvlo (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(in_norm & uv_flag_i),
    .tick_i(tick_i), .hit_o(hit_uv)
  );

  assign oc_hit = hit1 | hit2 | hit3;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORM: begin
        if (hit_uv)      state_d = ST_UVLO;  // lockout wins
        else if (oc_hit) state_d = ST_OC;
      end
      ST_OC:   if (release_i)  state_d = ST_NORM;
      ST_UVLO: if (!uv_flag_i) state_d = ST_NORM;
      default: state_d = ST_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NORM;
    else         state_q <= state_d;
  end

  assign fault      = !in_norm;
  assign sense_pd_o = fault;

  generate
    if (ACT_HIGH) begin : g_pol_high
      assign gate_oe_o = !fault;
    end else begin : g_pol_low
      assign gate_oe_o = fault;
    end
  endgenerate

  // driven level is always low; released pin is pulled high externally
  assign gate_lvl_o = !gate_oe_o;
endmodule

// File: rtl/ocp_ctrl_chk.sv
module ocp_ctrl_chk #(
  parameter bit TIER3_EN = 1'b1,
  parameter bit ACT_HIGH = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic oc1_flag_i,
  input logic oc3_flag_i,
  input logic uv_flag_i,
  input logic release_i,
  input logic gate_oe_o,
  input logic gate_lvl_o,
  input logic sense_pd_o
);
  // R9
  pd_matches_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_pd_o == (ACT_HIGH ? !gate_oe_o : gate_oe_o));

  // R10
  driven_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_oe_o |-> !gate_lvl_o);

  // R3
  trip_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sense_pd_o) |-> $past(tick_i));

  // R2
  trip_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sense_pd_o) |-> ($past(oc1_flag_i) || $past(uv_flag_i) ||
                           (TIER3_EN && $past(oc3_flag_i))));

  // R6
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_pd_o && !release_i && uv_flag_i) |=> sense_pd_o);

  // R7
  exit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sense_pd_o) |-> ($past(release_i) || !$past(uv_flag_i)));
endmodule

bind ocp_ctrl ocp_ctrl_chk #(.TIER3_EN(TIER3_EN), .ACT_HIGH(ACT_HIGH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .oc1_flag_i(oc1_flag_i),
  .oc3_flag_i(oc3_flag_i), .uv_flag_i(uv_flag_i), .release_i(release_i),
  .gate_oe_o(gate_oe_o), .gate_lvl_o(gate_lvl_o), .sense_pd_o(sense_pd_o)
);

// File: tb/ocp_ctrl_test.sv
module ocp_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int T1 = 20;
  localparam int T2 = 3;
  localparam int T3 = 2;
  localparam int UV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, oc1 = 1'b0, oc2 = 1'b0, oc3 = 1'b0, uv = 1'b0, rel = 1'b0;
  logic oe_a, lvl_a, pd_a, oe_b, lvl_b, pd_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // active-low build with tier 3
  ocp_ctrl #(.T1_TICKS(T1), .T2_TICKS(T2), .T3_TICKS(T3), .UV_TICKS(UV),
             .TIER3_EN(1'b1), .ACT_HIGH(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .oc1_flag_i(oc1),
    .oc2_flag_i(oc2), .oc3_flag_i(oc3), .uv_flag_i(uv), .release_i(rel),
    .gate_oe_o(oe_a), .gate_lvl_o(lvl_a), .sense_pd_o(pd_a)
  );

  // active-high build without tier 3
  ocp_ctrl #(.T1_TICKS(T1), .T2_TICKS(T2), .T3_TICKS(T3), .UV_TICKS(UV),
             .TIER3_EN(1'b0), .ACT_HIGH(1'b1)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .oc1_flag_i(oc1),
    .oc2_flag_i(oc2), .oc3_flag_i(oc3), .uv_flag_i(uv), .release_i(rel),
    .gate_oe_o(oe_b), .gate_lvl_o(lvl_b), .sense_pd_o(pd_b)
  );

  // R9 R10: pin expectations for both builds
  task automatic check(input bit fa, input bit fb, input string tag);
    total++;
    if (oe_a !== fa || lvl_a !== !fa || pd_a !== fa) begin
      bad++;
      $display("FAIL %s (R9 R10 a): oe=%b lvl=%b pd=%b expected oe=%b lvl=%b pd=%b",
               tag, oe_a, lvl_a, pd_a, fa, !fa, fa);
    end
    total++;
    if (oe_b !== !fb || lvl_b !== fb || pd_b !== fb) begin
      bad++;
      $display("FAIL %s (R9 R10 b): oe=%b lvl=%b pd=%b expected oe=%b lvl=%b pd=%b",
               tag, oe_b, lvl_b, pd_b, !fb, fb, fb);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    oc1 = 0; oc2 = 0; oc3 = 0; uv = 0; rel = 1;
    idle(1);
    rel = 0;
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(0, 0, "R1 reset");

    // R3: no ticks, no trip
    oc1 = 1; oc2 = 1; uv = 1;
    idle(200);
    check(0, 0, "R3 no tick");
    oc1 = 0; oc2 = 0; uv = 0;
    idle(1);

    // R2: every shorter run is harmless
    for (int k = 1; k < T1; k++) begin
      oc1 = 1;
      tick_n(k);
      check(0, 0, "R2 short run");
      oc1 = 0;
      idle(1);
    end
    oc1 = 1;
    tick_n(T1 - 1);
    check(0, 0, "R2 one short");
    tick_n(1);
    check(1, 1, "R2 trip");

    // R6: latched until release
    oc1 = 0;
    tick_n(3);
    idle(5);
    check(1, 1, "R6 hold");
    rel = 1;
    idle(1);
    rel = 0;
    check(0, 0, "R6 release");

    // R4: late tier-2 flag caught at next window boundary
    for (int d = 0; d < 8; d++) begin
      int n, exp_n;
      oc1 = 1;
      tick_n(d);
      check(0, 0, "R4 before tier2");
      oc2 = 1;
      n = 0;
      while (!pd_a && n < 30) begin
        tick_n(1);
        n++;
      end
      exp_n = ((d / T2) + 1) * T2 - d;
      total++;
      if (n != exp_n) begin
        bad++;
        $display("FAIL R4 delay d=%0d: ticks=%0d expected %0d", d, n, exp_n);
      end
      check(1, 1, "R4 tripped");
      clear_all();
    end

    // R4: short tier-2 pulse within window still counts
    oc1 = 1;
    tick_n(2);
    oc2 = 1;
    idle(1);
    oc2 = 0;
    check(0, 0, "R4 pulse pending");
    tick_n(1);
    check(1, 1, "R4 pulse trip");
    clear_all();

    // R4: tier-1 drop restarts the window
    oc1 = 1;
    tick_n(2);
    oc1 = 0;
    idle(1);
    oc1 = 1; oc2 = 1;
    tick_n(2);
    check(0, 0, "R4 restart");
    tick_n(1);
    check(1, 1, "R4 restart trip");
    clear_all();

    // R5: tier 3 trips only in the build that has it
    oc1 = 1; oc3 = 1;
    tick_n(T3 - 1);
    check(0, 0, "R5 short");
    tick_n(1);
    check(1, 0, "R5 tier3");
    clear_all();

    // R7: lockout qualify and immediate clear
    for (int k = 1; k < UV; k++) begin
      uv = 1;
      tick_n(k);
      check(0, 0, "R7 short");
      uv = 0;
      idle(1);
    end
    uv = 1;
    tick_n(UV);
    check(1, 1, "R7 lockout");
    idle(5);
    check(1, 1, "R7 held");
    uv = 0;
    idle(1);
    check(0, 0, "R7 clear");

    // R8: lockout and tier 3 qualify on the same tick
    uv = 1;
    tick_n(UV - T3);
    oc1 = 1; oc3 = 1;
    tick_n(T3);
    check(1, 1, "R8 fault");
    oc1 = 0; oc3 = 0; uv = 0;
    idle(1);
    check(0, 0, "R8 lockout chosen");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule